// File: doc/BRIEF.md
# Multi-mode DDS phase accumulator

This block is the phase-generation core of a direct digital synthesizer. A 48-bit accumulator adds an active frequency word once per system clock. It outputs the top bits of the running phase, which later stages convert to a waveform. The frequency word for a given output frequency is that frequency times 2^48, divided by the system clock frequency.

A 3-bit mode input decides where the active frequency comes from:

- Code 000 gives a single tone.
- Code 001 switches between two tuning words, selected by a keying pin.
- Code 010 moves toward the selected tuning word in bounded steps.
- Code 011 sweeps linearly from tuning word 1 by a signed step.
- Code 100 keeps tuning word 1 and uses the keying pin to add half a cycle to the output phase.

A synchronous master reset clears the block to a zero-frequency, zero-phase, single-tone state.

Top module: `mdds_top`

## Requirements
- R1: While `mrst_i` is high at a rising edge, the next `phase_o` is 0 and `flip_o` is 0. Afterwards, with all tuning words at zero, `phase_o` stays 0.
- R2: In mode 000 the internal phase advances by `ftw1_i` each clock. `phase_o` is bits 47..32 of that 48-bit phase.
- R3: In mode 001 the active frequency is `ftw1_i` when `key_i` is 0 and `ftw2_i` when `key_i` is 1.
- R4: In mode 010, if the frequency is below the selected word, it rises by `step_i` per clock. It stops exactly on the selected word without overshoot and then holds there.
- R5: In mode 010, if the frequency is above the selected word, it falls by `step_i` per clock and stops exactly on the selected word.
- R6: On the first clock of mode 011, the frequency loads `ftw1_i`. Each later clock in that mode adds `step_i`, read as a two's-complement value, modulo 2^48.
- R7: In mode 100 the frequency is `ftw1_i`. When `key_i` is 1, the next `phase_o` has its MSB inverted and `flip_o` is 1.
- R8: Mode codes 101, 110 and 111 behave exactly as mode 000.
- R9: The internal phase wraps modulo 2^48.
- R10: The frequency is registered before the accumulator, so a new tuning word first changes `phase_o` two clocks after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| mrst_i | input | 1 | Synchronous master reset, active high |
| mode_i | input | 3 | Mode code |
| ftw1_i | input | 48 | Tuning word 1 |
| ftw2_i | input | 48 | Tuning word 2 |
| step_i | input | 48 | Ramp magnitude or signed chirp step |
| key_i | input | 1 | Keying pin |
| phase_o | output | 16 | Truncated phase, including the BPSK flip |
| flip_o | output | 1 | Half-cycle flip active |

## Verification
A wrong active frequency shows up as a wrong phase increment one clock after the frequency register updates, and the error grows every cycle after that. Because of this, each cycle's `phase_o` is compared with a model that tracks frequency and phase separately. A ramp that overshoots, or a chirp that starts from the wrong base, diverges from the model within one or two clocks. A missing phase flip is visible on `phase_o[15]` in the very next cycle.

// File: rtl/mdds_pkg.sv
package mdds_pkg;

  typedef enum logic [2:0] {
    MD_TONE  = 3'd0,
    MD_FSK   = 3'd1,
    MD_RAMP  = 3'd2,
    MD_CHIRP = 3'd3,
    MD_BPSK  = 3'd4
  } mdds_mode_e;

  // Unused codes fold onto single tone.
  function automatic mdds_mode_e mode_decode(input logic [2:0] code);
    case (code)
      3'd1:    return MD_FSK;
      3'd2:    return MD_RAMP;
      3'd3:    return MD_CHIRP;
      3'd4:    return MD_BPSK;
      default: return MD_TONE;
    endcase
  endfunction

endpackage

// File: rtl/mdds_freq_ctrl.sv
module mdds_freq_ctrl
  import mdds_pkg::*;
#(
  parameter int ACC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  mdds_mode_e       mode_i,
  input  logic             key_i,
  input  logic [ACC_W-1:0] ftw1_i,
  input  logic [ACC_W-1:0] ftw2_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] freq_o
);

  function automatic logic [ACC_W-1:0] ramp_next(
    input logic [ACC_W-1:0] cur,
    input logic [ACC_W-1:0] tgt,
    input logic [ACC_W-1:0] stp
  );
    logic [ACC_W:0] up;
    up = {1'b0, cur} + {1'b0, stp};
    if (cur < tgt)      return (up >= {1'b0, tgt}) ? tgt : up[ACC_W-1:0];
    else if (cur > tgt) return (stp >= (cur - tgt)) ? tgt : (cur - stp);
    else                return tgt;
  endfunction

  function automatic logic [ACC_W-1:0] chirp_next(
    input logic [ACC_W-1:0] cur,
    input logic [ACC_W-1:0] stp
  );
    return cur + stp;
  endfunction

  logic [ACC_W-1:0] freq_q, freq_d;
  mdds_mode_e       last_mode_q;
  logic [ACC_W-1:0] ramp_tgt;
  logic             ramp_at_tgt;
  logic             chirp_start;

  assign ramp_tgt    = key_i ? ftw2_i : ftw1_i;
  assign ramp_at_tgt = (freq_q == ramp_tgt);
  assign chirp_start = (mode_i == MD_CHIRP) && (last_mode_q != MD_CHIRP);

  always_comb begin
    case (mode_i)
      MD_FSK:   freq_d = key_i ? ftw2_i : ftw1_i;
      MD_RAMP:  freq_d = ramp_next(freq_q, ramp_tgt, step_i);
      MD_CHIRP: freq_d = chirp_start ? ftw1_i : chirp_next(freq_q, step_i);
      default:  freq_d = ftw1_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      freq_q      <= '0;
      last_mode_q <= MD_TONE;
    end else begin
      freq_q      <= freq_d;
      last_mode_q <= mode_i;
    end
  end

  assign freq_o = freq_q;

  // R4
  ramp_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MD_RAMP && ramp_at_tgt) |=> (freq_q == $past(freq_q)));

  // R3
  fsk_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MD_FSK && key_i) |=> (freq_q == $past(ftw2_i)));

  // R6
  chirp_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    chirp_start |=> (freq_q == $past(ftw1_i)));

  // R8
  tone_alias_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MD_TONE || mode_i == MD_BPSK) |=> (freq_q == $past(ftw1_i)));

endmodule

// File: rtl/mdds_phase_acc.sv
module mdds_phase_acc #(
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [ACC_W-1:0]   freq_i,
  output logic [PHASE_W-1:0] phase_top_o
);

  function automatic logic [ACC_W-1:0] acc_add(
    input logic [ACC_W-1:0] a,
    input logic [ACC_W-1:0] b
  );
    return a + b;
  endfunction

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) acc_q <= '0;
    else       acc_q <= acc_add(acc_q, freq_i);
  end

  assign phase_top_o = acc_q[ACC_W-1 -: PHASE_W];

  // R10
  zero_freq_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (freq_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/mdds_phase_out.sv
module mdds_phase_out
  import mdds_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  mdds_mode_e         mode_i,
  input  logic               key_i,
  input  logic [PHASE_W-1:0] phase_top_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               flip_o
);

  localparam logic [PHASE_W-1:0] HALF_CYCLE = {1'b1, {(PHASE_W-1){1'b0}}};

  logic flip_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) flip_q <= 1'b0;
    else       flip_q <= (mode_i == MD_BPSK) && key_i;
  end

  assign phase_o = flip_q ? (phase_top_i ^ HALF_CYCLE) : phase_top_i;
  assign flip_o  = flip_q;

  // R7
  flip_msb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    flip_o |-> (phase_o[PHASE_W-1] != phase_top_i[PHASE_W-1]));

endmodule

// File: rtl/mdds_top.sv
module mdds_top
  import mdds_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 16,
  parameter int MODE_W  = 3
) (
  input  logic               clk_i,
  input  logic               mrst_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [ACC_W-1:0]   ftw1_i,
  input  logic [ACC_W-1:0]   ftw2_i,
  input  logic [ACC_W-1:0]   step_i,
  input  logic               key_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               flip_o
);

  mdds_mode_e         mode_dec;
  logic [ACC_W-1:0]   freq_w;
  logic [PHASE_W-1:0] phase_top_w;

  assign mode_dec = mode_decode(mode_i[2:0]);

  mdds_freq_ctrl #(.ACC_W(ACC_W)) u_freq (
    .clk_i (clk_i),
    .rst_i (mrst_i),
    .mode_i(mode_dec),
    .key_i (key_i),
    .ftw1_i(ftw1_i),
    .ftw2_i(ftw2_i),
    .step_i(step_i),
    .freq_o(freq_w)
  );

  mdds_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
    .clk_i      (clk_i),
    .rst_i      (mrst_i),
    .freq_i     (freq_w),
    .phase_top_o(phase_top_w)
  );

  mdds_phase_out #(.PHASE_W(PHASE_W)) u_out (
    .clk_i      (clk_i),
    .rst_i      (mrst_i),
    .mode_i     (mode_dec),
    .key_i      (key_i),
    .phase_top_i(phase_top_w),
    .phase_o    (phase_o),
    .flip_o     (flip_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    mrst_i |=> (phase_o == '0 && !flip_o));

endmodule

// File: tb/mdds_top_tb.sv
module mdds_top_tb_top;

  typedef struct packed {
    logic [2:0]  mode;
    logic        key;
    logic [47:0] f1;
    logic [47:0] f2;
    logic [47:0] stp;
    logic [7:0]  ncyc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 48'h0100_0000_0000, 48'h0,              48'h0,              8'd6}, // R2
    '{3'd1, 1'b0, 48'h0100_0000_0000, 48'h0300_0000_0000, 48'h0,              8'd4}, // R3
    '{3'd1, 1'b1, 48'h0100_0000_0000, 48'h0300_0000_0000, 48'h0,              8'd4}, // R3
    '{3'd2, 1'b0, 48'h0100_0000_0000, 48'h0300_0000_0000, 48'h0070_0000_0000, 8'd6}, // R5
    '{3'd2, 1'b1, 48'h0100_0000_0000, 48'h0300_0000_0000, 48'h0090_0000_0000, 8'd6}, // R4
    '{3'd3, 1'b0, 48'h0200_0000_0000, 48'h0,              48'hFFFF_F000_0000, 8'd6}, // R6
    '{3'd4, 1'b1, 48'h0080_0000_0000, 48'h0,              48'h0,              8'd4}, // R7
    '{3'd4, 1'b0, 48'h0080_0000_0000, 48'h0,              48'h0,              8'd3}, // R7
    '{3'd5, 1'b1, 48'h0123_4567_89AB, 48'h0,              48'h0,              8'd3}, // R8
    '{3'd6, 1'b1, 48'h0011_0000_0000, 48'h0,              48'h0,              8'd3}, // R8
    '{3'd7, 1'b1, 48'h0022_0000_0000, 48'h0,              48'h0,              8'd3}, // R8
    '{3'd0, 1'b0, 48'hFFFF_FFFF_FFFF, 48'h0,              48'h0,              8'd4}  // R9
  };

  logic        clk = 1'b0;
  logic        mrst = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic        key = 1'b0;
  logic [47:0] f1 = '0, f2 = '0, stp = '0;
  logic [15:0] phase;
  logic        flip;

  int checks = 0;
  int errors = 0;

  logic [47:0] m_freq = '0, m_acc = '0;
  logic        m_flip = 1'b0;
  logic [2:0]  m_last = 3'd0;

  always #4 clk = ~clk;

  mdds_top dut_i (
    .clk_i(clk), .mrst_i(mrst), .mode_i(mode), .ftw1_i(f1), .ftw2_i(f2),
    .step_i(stp), .key_i(key), .phase_o(phase), .flip_o(flip)
  );

  function automatic string req_of(input logic [2:0] m, input logic k);
    case (m)
      3'd1:    return "R3";
      3'd2:    return k ? "R4" : "R5";
      3'd3:    return "R6";
      3'd4:    return "R7";
      3'd0:    return "R2";
      default: return "R8";
    endcase
  endfunction

  // Effective mode: codes above 4 act as single tone.
  function automatic logic [2:0] eff(input logic [2:0] m);
    return (m > 3'd4) ? 3'd0 : m;
  endfunction

  task automatic check(input string req, input logic [15:0] exp_p, input logic exp_f);
    checks++;
    if (phase !== exp_p || flip !== exp_f) begin
      errors++;
      $display("FAIL %s: phase=%h flip=%b expected phase=%h flip=%b",
               req, phase, flip, exp_p, exp_f);
    end
  endtask

  // Advance the reference by one clock from the current inputs.
  task automatic model_step();
    logic [47:0] tgt, nf, gap;
    logic [2:0]  em;
    if (mrst) begin
      m_freq = '0; m_acc = '0; m_flip = 1'b0; m_last = 3'd0;
      return;
    end
    em  = eff(mode);
    tgt = key ? f2 : f1;
    nf  = f1;
    if (em == 3'd1) nf = tgt;
    else if (em == 3'd2) begin
      if (m_freq < tgt) begin
        gap = tgt - m_freq;
        nf  = (stp >= gap) ? tgt : m_freq + stp;
      end else begin
        gap = m_freq - tgt;
        nf  = (stp >= gap) ? tgt : m_freq - stp;
      end
    end else if (em == 3'd3) nf = (m_last == 3'd3) ? m_freq + stp : f1;
    m_acc  = m_acc + m_freq;
    m_freq = nf;
    m_flip = (em == 3'd4) && key;
    m_last = em;
  endtask

  function automatic logic [15:0] exp_phase();
    return m_acc[47:32] ^ {m_flip, 15'h0};
  endfunction

  task automatic cycle(input string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(req, exp_phase(), m_flip);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    mrst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", 16'h0, 1'b0);
    mrst = 1'b0;
    for (int i = 0; i < 3; i++) cycle("R1");

    // R10: latency of a new tuning word
    @(negedge clk);
    mode = 3'd0; f1 = 48'h0400_0000_0000;
    model_step(); @(posedge clk); @(negedge clk);
    check("R10", 16'h0000, 1'b0);
    model_step(); @(posedge clk); @(negedge clk);
    check("R10", 16'h0400, 1'b0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      mode = VECS[v].mode; key = VECS[v].key;
      f1 = VECS[v].f1; f2 = VECS[v].f2; stp = VECS[v].stp;
      for (int c = 0; c < int'(VECS[v].ncyc); c++) cycle(req_of(VECS[v].mode, VECS[v].key));
    end

    // R6: chirp re-entry restarts from tuning word 1 with a positive step
    mode = 3'd0; f1 = 48'h0;
    cycle("R6");
    mode = 3'd3; f1 = 48'h0010_0000_0000; stp = 48'h0001_0000_0000;
    for (int i = 0; i < 5; i++) cycle("R6");

    // R4: ramp up with a step far larger than the gap clamps at once
    mode = 3'd2; key = 1'b1; f2 = 48'h0020_0000_0000; stp = 48'hF000_0000_0000;
    for (int i = 0; i < 4; i++) cycle("R4");

    // R1: reset mid-run with a flip active
    mode = 3'd4; key = 1'b1; f1 = 48'h0333_0000_0000;
    cycle("R7"); cycle("R7");
    mrst = 1'b1;
    cycle("R1");
    check("R1", 16'h0, 1'b0);
    mrst = 1'b0; mode = 3'd0; key = 1'b0; f1 = '0;
    for (int i = 0; i < 3; i++) cycle("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule